// File: doc/BRIEF.md
# Transmit Frame Retry and Status Tracker

This block follows each transmit frame of a half-duplex Ethernet MAC from the moment it becomes ready until software collects its outcome. The transmit engine reports per-attempt events to it: an attempt has started, and the attempt ended with a success, a normal collision, a late collision or a loss of carrier. From these events the block keeps a 4-bit retry count. After each collision it either requests another attempt or aborts the frame. At the end it builds a status byte for the frame.

The block also records whether the channel was busy when the frame became ready, and whether the wait before the first attempt went past a programmable bit-time limit. It hides carrier-loss reports in configurations where carrier is not meaningful. It holds off the transmit data request after a fatal abort until the status byte has been read. When a frame completes, a status-valid level and a one-cycle interrupt pulse announce it. A read strobe collects the status and frees the block for the next frame. A new frame is accepted only when no status is pending.

Top module: `txretry_tracker`

## Requirements
- R1: After reset, retry_cnt is 0, stat_byte is 0, stat_valid, irq and retry_go are 0, and tx_dreq_en is 1.
- R2: A collision with retries left raises retry_go for one cycle and increments retry_cnt. Both are visible one clock after the collision pulse. A later success leaves the count n at its value. In stat_byte, bit 1 (one) reads n==1 and bit 2 (more) reads n>1.
- R3: A collision arriving when retry_cnt is 15 (the 16th failed attempt) aborts the frame without retry_go. It sets bit 3 (retry error), and retry_cnt stays 15.
- R4: With no_retry high, the first collision aborts the frame with bit 3 set, retry_cnt 0 and no retry_go.
- R5: At most one of stat_byte bits 1, 2 and 3 is ever set.
- R6: Bit 6 (deferred) equals chan_busy sampled in the cycle the frame is accepted.
- R7: Bit 7 (excessive defer) is set when more than EXDEF_BITS bit_tick pulses occur between frame acceptance and the first attempt start. Exactly EXDEF_BITS pulses leave it clear.
- R8: A late collision or a reported carrier loss ends the frame at once, with no retry_go. A late collision sets bit 4 and a carrier loss sets bit 5.
- R9: With loopback high, or with tp_sel and tp_link_ok both high, a carrier-loss pulse is not reported and the attempt counts as a success with bit 5 clear. With tp_sel high, tp_link_ok low and loopback low, bit 5 is set at the completion of every frame, including a successful one.
- R10: A stat_rd pulse while stat_valid is high clears retry_cnt, stat_byte and stat_valid on the next clock. After a retry-error or late-collision abort, tx_dreq_en stays low from completion until that read.
- R11: One clock after the ending event, stat_valid rises and irq pulses high for exactly one cycle. Bit 0 of stat_byte always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_ready | input | 1 | A frame is ready to send (accepted only when idle) |
| chan_busy | input | 1 | Channel carrier currently sensed |
| bit_tick | input | 1 | One pulse per bit time |
| att_start | input | 1 | Transmit attempt begins |
| att_ok | input | 1 | Attempt completed successfully |
| att_coll | input | 1 | Attempt ended in a normal collision |
| att_late | input | 1 | Attempt ended in a late collision |
| att_lcar | input | 1 | Carrier lost during attempt |
| no_retry | input | 1 | Single-attempt mode |
| tp_sel | input | 1 | Twisted-pair port selected |
| tp_link_ok | input | 1 | Twisted-pair link in pass state |
| loopback | input | 1 | Internal loopback active |
| stat_rd | input | 1 | Status register read strobe |
| retry_cnt | output | 4 | Retries used for the current frame |
| stat_byte | output | 8 | Frame status: 7 exdef, 6 defer, 5 carrier loss, 4 late coll, 3 retry err, 2 more, 1 one, 0 zero |
| stat_valid | output | 1 | Status pending read |
| irq | output | 1 | Completion interrupt pulse |
| retry_go | output | 1 | Back off and retry request pulse |
| tx_dreq_en | output | 1 | Transmit data request permitted |

## Verification
The assertions check on every cycle that the one, more and retry-error flags stay exclusive and that irq is a single-cycle pulse inside a valid status. They also check that a retry pulse always advances the count by one, that a read clears the status, and that the data request is only held off while status is pending. Only the bench scenarios can show the arithmetic outcomes. These are the count for every collision total from 0 to 16, the exact boundary of the excessive-defer limit, single-attempt mode, and the carrier-loss rules across all eight port, link and loopback combinations.

// File: rtl/txr_pkg.sv
// Shared types for the transmit retry tracker.
// Assumes: one frame in flight at a time.
package txr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ATT,
        ST_BACK,
        ST_DONE
    } txr_state_e;

    // Final outcome of a frame, valid with the done strobe
    typedef struct packed {
        logic ok;
        logic rtry;
        logic lcol;
        logic lcar;
    } txr_fin_t;

    // Status byte layout, MSB first
    typedef struct packed {
        logic exdef;
        logic defer;
        logic lcar;
        logic lcol;
        logic rtry;
        logic more;
        logic one;
        logic zero;
    } txr_stat_t;

endpackage

// File: rtl/txr_defer_timer.sv
// Deferral monitor: samples the channel state when a frame is accepted and
// counts bit times until the first attempt starts.
// Assumes: accept is a one-cycle strobe; waiting is high only before the
// first attempt of the frame.
module txr_defer_timer #(
    parameter int EXDEF_BITS = 24288
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic chan_busy,
    input  logic waiting,
    input  logic bit_tick,
    output logic defer_flag,
    output logic exdef_flag
);
    localparam int DW = $clog2(EXDEF_BITS + 2);
    localparam logic [DW-1:0] LIMIT = DW'(EXDEF_BITS);

    logic [DW-1:0] wait_cnt;

    // Capture channel state and count bit times while waiting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt   <= '0;
            defer_flag <= 1'b0;
        end else if (accept) begin
            wait_cnt   <= '0;
            defer_flag <= chan_busy;
        end else if (waiting && bit_tick && wait_cnt <= LIMIT) begin
            wait_cnt <= wait_cnt + 1'b1;
        end
    end

    // Limit exceeded once the count passes the threshold
    always_comb exdef_flag = (wait_cnt > LIMIT);

endmodule

// File: rtl/txr_retry_ctl.sv
// Frame sequencer: tracks the attempt state, counts retries and decides
// between retry and abort for each attempt outcome.
// Assumes: outcome pulses arrive only while an attempt is in progress.
module txr_retry_ctl
    import txr_pkg::*;
#(
    parameter int MAX_TRIES = 16,
    parameter int CW = $clog2(MAX_TRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_ready,
    input  logic          att_start,
    input  logic          ok_hit,
    input  logic          coll_hit,
    input  logic          late_hit,
    input  logic          lcar_hit,
    input  logic          no_retry,
    input  logic          stat_rd,
    output logic          accept,
    output logic          waiting,
    output logic          done,
    output txr_fin_t      fin,
    output logic [CW-1:0] cnt,
    output logic          retry_go
);
    localparam logic [CW-1:0] CAP = CW'(MAX_TRIES - 1);

    txr_state_e    st, st_nx;
    logic [CW-1:0] cnt_nx;
    logic          retry_nx;

    // Next-state and outcome decision
    always_comb begin
        st_nx    = st;
        cnt_nx   = cnt;
        retry_nx = 1'b0;
        done     = 1'b0;
        fin      = '0;
        case (st)
            ST_IDLE: if (frame_ready) begin
                st_nx  = ST_WAIT;
                cnt_nx = '0;
            end
            ST_WAIT, ST_BACK: if (att_start) st_nx = ST_ATT;
            ST_ATT: begin
                if (late_hit) begin
                    done     = 1'b1;
                    fin.lcol = 1'b1;
                end else if (lcar_hit) begin
                    done     = 1'b1;
                    fin.lcar = 1'b1;
                end else if (coll_hit) begin
                    if (no_retry || cnt == CAP) begin
                        done     = 1'b1;
                        fin.rtry = 1'b1;
                    end else begin
                        cnt_nx   = cnt + 1'b1;
                        retry_nx = 1'b1;
                        st_nx    = ST_BACK;
                    end
                end else if (ok_hit) begin
                    done   = 1'b1;
                    fin.ok = 1'b1;
                end
                if (done) st_nx = ST_DONE;
            end
            ST_DONE: if (stat_rd) begin
                st_nx  = ST_IDLE;
                cnt_nx = '0;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // State, count and retry pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            retry_go <= 1'b0;
        end else begin
            st       <= st_nx;
            cnt      <= cnt_nx;
            retry_go <= retry_nx;
        end
    end

    // Strobes for the neighbour blocks
    always_comb begin
        accept  = (st == ST_IDLE) && frame_ready;
        waiting = (st == ST_WAIT);
    end

endmodule

// File: rtl/txr_status.sv
// Status register: assembles the frame status byte at completion, raises
// the valid level and interrupt pulse, and holds off the data request
// after fatal aborts until the status is read.
// Assumes: done is a one-cycle strobe and cannot coincide with a read.
module txr_status
    import txr_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done,
    input  txr_fin_t      fin,
    input  logic [CW-1:0] cnt,
    input  logic          lcar_force,
    input  logic          defer_flag,
    input  logic          exdef_flag,
    input  logic          stat_rd,
    output txr_stat_t     stat,
    output logic          valid,
    output logic          irq,
    output logic          hold
);
    txr_stat_t fresh;

    // Build the status byte from the outcome
    always_comb begin
        fresh       = '0;
        fresh.exdef = exdef_flag;
        fresh.defer = defer_flag;
        fresh.lcar  = fin.lcar | lcar_force;
        fresh.lcol  = fin.lcol;
        fresh.rtry  = fin.rtry;
        fresh.one   = fin.ok && (cnt == CW'(1));
        fresh.more  = fin.ok && (cnt > CW'(1));
    end

    // Latch on completion, clear on read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat  <= '0;
            valid <= 1'b0;
            irq   <= 1'b0;
            hold  <= 1'b0;
        end else begin
            irq <= done;
            if (done) begin
                stat  <= fresh;
                valid <= 1'b1;
                hold  <= fin.rtry | fin.lcol;
            end else if (stat_rd && valid) begin
                stat  <= '0;
                valid <= 1'b0;
                hold  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/txretry_tracker.sv
// Top of the transmit retry tracker: qualifies carrier-loss events by the
// port, link and loopback state and connects sequencer, deferral monitor
// and status register.
// Assumes: inputs are synchronous to clk; one outcome pulse per attempt.
module txretry_tracker
    import txr_pkg::*;
#(
    parameter int MAX_TRIES  = 16,
    parameter int EXDEF_BITS = 24288
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_ready,
    input  logic       chan_busy,
    input  logic       bit_tick,
    input  logic       att_start,
    input  logic       att_ok,
    input  logic       att_coll,
    input  logic       att_late,
    input  logic       att_lcar,
    input  logic       no_retry,
    input  logic       tp_sel,
    input  logic       tp_link_ok,
    input  logic       loopback,
    input  logic       stat_rd,
    output logic [3:0] retry_cnt,
    output logic [7:0] stat_byte,
    output logic       stat_valid,
    output logic       irq,
    output logic       retry_go,
    output logic       tx_dreq_en
);
    localparam int CW = $clog2(MAX_TRIES);

    logic          lcar_quiet, lcar_force, lcar_hit, ok_hit;
    logic          accept, waiting, done, hold;
    logic          defer_flag, exdef_flag;
    logic [CW-1:0] cnt;
    txr_fin_t      fin;
    txr_stat_t     stat;

    // Carrier-loss qualification by port and link state
    always_comb begin
        lcar_quiet = loopback || (tp_sel && tp_link_ok);
        lcar_force = tp_sel && !tp_link_ok && !loopback;
        lcar_hit   = att_lcar && !lcar_quiet;
        ok_hit     = att_ok || (att_lcar && lcar_quiet);
    end

    txr_retry_ctl #(.MAX_TRIES(MAX_TRIES), .CW(CW)) u_ctl (
        .clk(clk), .rst_n(rst_n), .frame_ready(frame_ready),
        .att_start(att_start), .ok_hit(ok_hit), .coll_hit(att_coll),
        .late_hit(att_late), .lcar_hit(lcar_hit), .no_retry(no_retry),
        .stat_rd(stat_rd), .accept(accept), .waiting(waiting),
        .done(done), .fin(fin), .cnt(cnt), .retry_go(retry_go)
    );

    txr_defer_timer #(.EXDEF_BITS(EXDEF_BITS)) u_defer (
        .clk(clk), .rst_n(rst_n), .accept(accept), .chan_busy(chan_busy),
        .waiting(waiting), .bit_tick(bit_tick),
        .defer_flag(defer_flag), .exdef_flag(exdef_flag)
    );

    txr_status #(.CW(CW)) u_stat (
        .clk(clk), .rst_n(rst_n), .done(done), .fin(fin), .cnt(cnt),
        .lcar_force(lcar_force), .defer_flag(defer_flag),
        .exdef_flag(exdef_flag), .stat_rd(stat_rd), .stat(stat),
        .valid(stat_valid), .irq(irq), .hold(hold)
    );

    // Output mapping
    always_comb begin
        retry_cnt  = 4'(cnt);
        stat_byte  = stat;
        tx_dreq_en = !hold;
    end

endmodule

// File: rtl/txr_checker.sv
// Cycle-level properties of the retry tracker, bound to its top module.
// Assumes: synchronous active-low reset on rst_n.
module txr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       att_late,
    input logic       stat_rd,
    input logic [3:0] retry_cnt,
    input logic [7:0] stat_byte,
    input logic       stat_valid,
    input logic       irq,
    input logic       retry_go,
    input logic       tx_dreq_en
);
    // R5: one, more and retry-error exclusive
    a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(stat_byte[3:1]) <= 1);

    // R11: interrupt is a single-cycle pulse
    a_r11_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R11: interrupt only with pending status
    a_r11_irq_valid: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> stat_valid);

    // R2: every retry pulse follows a count step of one
    a_r2_retry_step: assert property (@(posedge clk) disable iff (!rst_n)
        retry_go |-> retry_cnt == 4'($past(retry_cnt) + 4'd1));

    // R10: read of pending status clears it
    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && stat_valid) |=> (!stat_valid && retry_cnt == 4'd0 && stat_byte == 8'd0));

    // R10: data request held off only while status is pending
    a_r10_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_dreq_en |-> stat_valid);

    // R8: no retry after a late collision
    a_r8_no_retry_late: assert property (@(posedge clk) disable iff (!rst_n)
        att_late |=> !retry_go);

    // R11: status byte bit 0 always zero
    a_r11_zero_bit: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_byte[0]);

endmodule

bind txretry_tracker txr_checker u_chk (
    .clk(clk), .rst_n(rst_n), .att_late(att_late), .stat_rd(stat_rd),
    .retry_cnt(retry_cnt), .stat_byte(stat_byte), .stat_valid(stat_valid),
    .irq(irq), .retry_go(retry_go), .tx_dreq_en(tx_dreq_en)
);

// File: tb/sim_txretry_tracker.sv
// Self-checking bench: sweeps collision totals, modes and boundaries.
module sim_txretry_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 24288;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_ready = 0, chan_busy = 0, bit_tick = 0, att_start = 0;
    logic att_ok = 0, att_coll = 0, att_late = 0, att_lcar = 0;
    logic no_retry = 0, tp_sel = 0, tp_link_ok = 0, loopback = 0, stat_rd = 0;
    logic [3:0] retry_cnt;
    logic [7:0] stat_byte;
    logic stat_valid, irq, retry_go, tx_dreq_en;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    txretry_tracker #(.MAX_TRIES(16), .EXDEF_BITS(LIMIT)) u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] mk(input bit exd, input bit dfr, input bit lc,
            input bit lcl, input bit rt, input bit mr, input bit on);
        return {exd, dfr, lc, lcl, rt, mr, on, 1'b0};
    endfunction

    task automatic start_frame(input bit busy);
        @(negedge clk); frame_ready = 1; chan_busy = busy;
        @(negedge clk); frame_ready = 0; chan_busy = 0;
    endtask

    // kind: 0 ok, 1 coll, 2 late, 3 lcar
    task automatic attempt(input int kind);
        @(negedge clk); att_start = 1;
        @(negedge clk); att_start = 0;
        att_ok = (kind == 0); att_coll = (kind == 1);
        att_late = (kind == 2); att_lcar = (kind == 3);
        @(negedge clk);
        att_ok = 0; att_coll = 0; att_late = 0; att_lcar = 0;
    endtask

    task automatic read_status();
        @(negedge clk); stat_rd = 1;
        @(negedge clk); stat_rd = 0;
        check("R10 valid cleared", int'(stat_valid), 0);
        check("R10 cnt cleared", int'(retry_cnt), 0);
        check("R10 stat cleared", int'(stat_byte), 0);
        check("R10 dreq restored", int'(tx_dreq_en), 1);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 cnt", int'(retry_cnt), 0);
        check("R1 stat", int'(stat_byte), 0);
        check("R1 valid", int'(stat_valid), 0);
        check("R1 irq", int'(irq), 0);
        check("R1 retry", int'(retry_go), 0);
        check("R1 dreq", int'(tx_dreq_en), 1);

        // R2 R3 sweep of collision totals 0..16
        for (int n = 0; n <= 16; n++) begin
            start_frame(0);
            for (int k = 0; k < n; k++) begin
                attempt(1);
                if (k < 15) begin
                    check("R2 retry pulse", int'(retry_go), 1);
                    check("R2 count step", int'(retry_cnt), k + 1);
                end else begin
                    check("R3 no retry at cap", int'(retry_go), 0);
                    check("R3 count held", int'(retry_cnt), 15);
                    check("R3 status", int'(stat_byte), int'(mk(0,0,0,0,1,0,0)));
                    check("R10 dreq held", int'(tx_dreq_en), 0);
                    check("R11 irq", int'(irq), 1);
                end
            end
            if (n < 16) begin
                attempt(0);
                check("R2 final count", int'(retry_cnt), n);
                check("R2 status one/more", int'(stat_byte),
                      int'(mk(0,0,0,0,0, n > 1, n == 1)));
                check("R11 valid", int'(stat_valid), 1);
                check("R11 irq", int'(irq), 1);
                @(negedge clk);
                check("R11 irq single", int'(irq), 0);
            end
            read_status();
        end

        // R4 single-attempt mode
        no_retry = 1;
        start_frame(0);
        attempt(1);
        check("R4 no retry", int'(retry_go), 0);
        check("R4 count", int'(retry_cnt), 0);
        check("R4 status", int'(stat_byte), int'(mk(0,0,0,0,1,0,0)));
        read_status();
        no_retry = 0;

        // R8 late collision after 3 retries
        start_frame(0);
        for (int k = 0; k < 3; k++) attempt(1);
        attempt(2);
        check("R8 late no retry", int'(retry_go), 0);
        check("R8 late status", int'(stat_byte), int'(mk(0,0,0,1,0,0,0)));
        check("R10 dreq held late", int'(tx_dreq_en), 0);
        repeat (3) @(negedge clk);
        check("R10 dreq still held", int'(tx_dreq_en), 0);
        read_status();

        // R6 deferral sampled at acceptance
        for (int b = 0; b < 2; b++) begin
            start_frame(b[0]);
            attempt(0);
            check("R6 defer flag", int'(stat_byte), int'(mk(0, b[0], 0,0,0,0,0)));
            read_status();
        end

        // R7 excessive defer boundary
        for (int t = LIMIT; t <= LIMIT + 1; t++) begin
            start_frame(0);
            @(negedge clk); bit_tick = 1;
            repeat (t) @(negedge clk);
            bit_tick = 0;
            attempt(0);
            check("R7 exdef boundary", int'(stat_byte), int'(mk(t > LIMIT, 0,0,0,0,0,0)));
            read_status();
        end

        // R8 R9 carrier loss and success across port/link/loopback
        for (int m = 0; m < 8; m++) begin
            bit quiet, force_l;
            tp_sel = m[0]; tp_link_ok = m[1]; loopback = m[2];
            quiet   = m[2] || (m[0] && m[1]);
            force_l = m[0] && !m[1] && !m[2];
            start_frame(0);
            attempt(1);
            attempt(3);
            check("R9 R8 lcar retry", int'(retry_go), 0);
            check("R9 lcar outcome", int'(stat_byte),
                  int'(mk(0,0, !quiet, 0,0,0, quiet)));
            read_status();
            start_frame(0);
            attempt(0);
            check("R9 success lcar flag", int'(stat_byte), int'(mk(0,0, force_l, 0,0,0,0)));
            read_status();
        end
        tp_sel = 0; tp_link_ok = 0; loopback = 0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule